// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Evaluator

The block grades a set of test vectors against every single stuck-at fault of a small fixed gate network. Every net of the network is carried as a word of `LANES` bits, one bit per copy of the network. Bit 0 is the good copy. Each other bit carries one fault taken from the fault list, so one good copy and `LANES-1` faulty copies are evaluated in the same cycle. A faulty lane is flagged when its outputs differ from those of lane 0.

A sweep starts with a `start` pulse. A sequencer splits the fault list into batches of `LANES-1` faults. For each batch it clears a sticky per-lane record and fetches the vectors in order through `vec_idx`/`vec_in`. It reports the flags for each vector, and then lists the IDs of the faults that the batch's vectors detected. Lanes with no fault in the last, partial batch are masked. `done` rises after the last batch.

The fixed network has inputs A, B, C and D, which are `vec_in` bits 0 to 3. Its gates are N4 = NAND(A,B), N5 = OR(C,D), N6 = XOR(N4,C) and N7 = NAND(N5,N6). Its outputs are N6 and N7.

Top module: `fev_fault_eval`

## Requirements
- R1: Lines are numbered A=0, B=1, C=2, D=3, N4=4, N5=5, N6=6, N7=7. Fault ID f forces line f>>1 to the value f[0] in its lane, so ID 2L is stuck-at-0 and ID 2L+1 is stuck-at-1. The list holds IDs 0..NUM_FAULTS-1 (NUM_FAULTS at most 16).
- R2: Lane 0 is never faulted and `det_mask[0]` is always 0. In batch b, lane k (1..LANES-1) carries fault ID b*(LANES-1)+k-1.
- R3: For each vector index 0..V-1 in turn, V = `num_vecs` captured at start (0 is taken as 1), `vec_in` is sampled while `vec_idx` shows that index. One cycle later `det_valid` pulses with `det_mask` bit k set exactly when lane k's two outputs differ from lane 0's.
- R4: Within a batch, detections from all vectors are ORed into a sticky record. The record is cleared before each batch, so a batch reports each fault detected by any of the V vectors, and only those.
- R5: Lanes whose fault ID would be NUM_FAULTS or more have `det_mask` bit 0 and are never reported.
- R6: A sweep runs ceil(NUM_FAULTS/(LANES-1)) batches. After a batch's vectors, `rpt_valid` pulses once per detected fault, with `rpt_fault` giving the ID, in ascending ID order.
- R7: `busy` is high from the cycle after an accepted start until the last report. `done` rises with the last report and holds until the next start, which clears it.
- R8: A `start` pulse while a sweep is running has no effect on that sweep.
- R9: After reset, `busy`, `done`, `det_valid` and `rpt_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| num_vecs | input | VEC_W | Vectors per batch (0 means 1) |
| vec_idx | output | VEC_W | Index of the vector requested |
| vec_in | input | 4 | Vector for `vec_idx`, bit i drives input line i |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished |
| det_valid | output | 1 | Per-vector detect mask valid |
| det_mask | output | LANES | Lanes whose outputs differ from lane 0 |
| rpt_valid | output | 1 | Detected fault ID valid |
| rpt_fault | output | $clog2(NUM_FAULTS) | Detected fault ID |

## Verification
Assertions check on every cycle that lane 0 is never flagged and that masked lanes stay silent. They also check that the sticky record never loses a bit inside a batch, that reported IDs stay inside the list, and that `done` and `busy` are never high together. Only the bench's sweeps can show that each detect mask matches a stuck-at model of the network. They also show the batch-to-lane assignment, the per-batch clearing, the report order and count, the zero-vector case, and that a start pulse during a sweep is ignored.

// File: rtl/fev_pkg.sv
// fev_pkg: constants and types shared by the fault evaluator.
// Assumes the fixed eight-line network described in the brief.
package fev_pkg;
    localparam int unsigned IN_W     = 4;   // primary inputs
    localparam int unsigned LINE_CNT = 8;   // lines that can be faulted
    localparam int unsigned OUT_W    = 2;   // primary outputs
    localparam int unsigned FAULT_MAX = 2 * LINE_CNT;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_EVAL,
        ST_REPORT
    } fev_state_t;
endpackage

// File: rtl/fev_mask_gen.sv
// fev_mask_gen: turns a batch base ID into per-line force masks.
// Lane k (k>=1) carries fault ID base+k-1; ID f forces line f>>1 to f[0].
// Lane 0 is never forced. Lanes whose ID is past the list are marked invalid.
module fev_mask_gen
    import fev_pkg::*;
#(
    parameter int unsigned LANES      = 16,
    parameter int unsigned NUM_FAULTS = 16,
    parameter int unsigned BASE_W     = 6
) (
    input  logic [BASE_W-1:0]                base,
    output logic [LINE_CNT-1:0][LANES-1:0]   sa0,
    output logic [LINE_CNT-1:0][LANES-1:0]   sa1,
    output logic [LANES-1:0]                 lane_ok
);
    // lane 0 stays fault-free
    assign lane_ok[0] = 1'b0;

    genvar gl;
    generate
        for (gl = 0; gl < LINE_CNT; gl++) begin : g_lane0
            assign sa0[gl][0] = 1'b0;
            assign sa1[gl][0] = 1'b0;
        end
    endgenerate

    genvar gk, gn;
    generate
        for (gk = 1; gk < LANES; gk++) begin : g_lane
            logic [BASE_W-1:0] fid;
            // fault ID carried by this lane
            assign fid = base + BASE_W'(gk - 1);
            // lane holds a real fault only inside the list
            assign lane_ok[gk] = (fid < BASE_W'(NUM_FAULTS));
            for (gn = 0; gn < LINE_CNT; gn++) begin : g_line
                // force this line in this lane when the ID selects it
                assign sa0[gn][gk] = lane_ok[gk] && (fid[BASE_W-1:1] == (BASE_W-1)'(gn)) && !fid[0];
                assign sa1[gn][gk] = lane_ok[gk] && (fid[BASE_W-1:1] == (BASE_W-1)'(gn)) &&  fid[0];
            end
        end
    endgenerate
endmodule

// File: rtl/fev_lane_net.sv
// fev_lane_net: the fixed gate network evaluated on LANES-wide words.
// Each line is forced per lane with (value & ~sa0) | sa1 before use.
// Assumes sa0 and sa1 never set the same bit.
module fev_lane_net
    import fev_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic [IN_W-1:0]                 vec,
    input  logic [LINE_CNT-1:0][LANES-1:0]  sa0,
    input  logic [LINE_CNT-1:0][LANES-1:0]  sa1,
    output logic [OUT_W-1:0][LANES-1:0]     outs
);
    logic [LANES-1:0] raw [LINE_CNT];
    logic [LANES-1:0] ln  [LINE_CNT];

    genvar gi;
    generate
        for (gi = 0; gi < IN_W; gi++) begin : g_in
            // broadcast each input bit to every lane
            assign raw[gi] = {LANES{vec[gi]}};
        end
        for (gi = 0; gi < LINE_CNT; gi++) begin : g_force
            // apply stuck-at forcing on every line
            assign ln[gi] = (raw[gi] & ~sa0[gi]) | sa1[gi];
        end
    endgenerate

    // gate layer, lane-parallel
    assign raw[4] = ~(ln[0] & ln[1]);
    assign raw[5] =   ln[2] | ln[3];
    assign raw[6] =   ln[4] ^ ln[2];
    assign raw[7] = ~(ln[5] & ln[6]);

    assign outs[0] = ln[6];
    assign outs[1] = ln[7];
endmodule

// File: rtl/fev_detect.sv
// fev_detect: flags lanes whose outputs differ from lane 0.
// Lanes not holding a fault are masked by lane_ok.
module fev_detect
    import fev_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic [OUT_W-1:0][LANES-1:0] outs,
    input  logic [LANES-1:0]            lane_ok,
    output logic [LANES-1:0]            det
);
    logic [LANES-1:0] diff;

    // compare every output lane against the good lane and OR over outputs
    always_comb begin
        diff = '0;
        for (int o = 0; o < OUT_W; o++) begin
            diff = diff | (outs[o] ^ {LANES{outs[o][0]}});
        end
        det = diff & lane_ok;
    end
endmodule

// File: rtl/fev_fault_eval.sv
// fev_fault_eval: sequences batches of faults through the lane network.
// Per batch: clear the sticky record, apply V vectors, then walk the lanes
// and report detected fault IDs. Assumes vec_in answers vec_idx in the same cycle.
module fev_fault_eval
    import fev_pkg::*;
#(
    parameter int unsigned LANES      = 16,
    parameter int unsigned NUM_FAULTS = 16,
    parameter int unsigned VEC_W      = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [VEC_W-1:0]              num_vecs,
    output logic [VEC_W-1:0]              vec_idx,
    input  logic [IN_W-1:0]               vec_in,
    output logic                          busy,
    output logic                          done,
    output logic                          det_valid,
    output logic [LANES-1:0]              det_mask,
    output logic                          rpt_valid,
    output logic [$clog2(NUM_FAULTS)-1:0] rpt_fault
);
    localparam int unsigned BASE_W = $clog2(NUM_FAULTS + LANES) + 1;
    localparam int unsigned LP_W   = $clog2(LANES);
    localparam int unsigned FID_W  = $clog2(NUM_FAULTS);

    fev_state_t                         state;
    logic [BASE_W-1:0]                  base;
    logic [VEC_W-1:0]                   nv_q;
    logic [LANES-1:0]                   acc;
    logic [LP_W-1:0]                    lane_ptr;
    logic [LINE_CNT-1:0][LANES-1:0]     sa0, sa1;
    logic [LANES-1:0]                   lane_ok;
    logic [OUT_W-1:0][LANES-1:0]        outs;
    logic [LANES-1:0]                   det;
    logic                               last_batch;
    logic [BASE_W-1:0]                  rpt_id;

    fev_mask_gen #(.LANES(LANES), .NUM_FAULTS(NUM_FAULTS), .BASE_W(BASE_W)) u_masks (
        .base(base), .sa0(sa0), .sa1(sa1), .lane_ok(lane_ok)
    );

    fev_lane_net #(.LANES(LANES)) u_net (
        .vec(vec_in), .sa0(sa0), .sa1(sa1), .outs(outs)
    );

    fev_detect #(.LANES(LANES)) u_det (
        .outs(outs), .lane_ok(lane_ok), .det(det)
    );

    // batch is final when its last lane reaches the end of the list
    assign last_batch = (base + BASE_W'(LANES - 1)) >= BASE_W'(NUM_FAULTS);
    // fault ID of the lane under the report pointer
    assign rpt_id = base + BASE_W'(lane_ptr) - BASE_W'(1);

    // sweep sequencer and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base      <= '0;
            nv_q      <= '0;
            acc       <= '0;
            lane_ptr  <= '0;
            vec_idx   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            det_valid <= 1'b0;
            det_mask  <= '0;
            rpt_valid <= 1'b0;
            rpt_fault <= '0;
        end else begin
            det_valid <= 1'b0;
            rpt_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        nv_q  <= (num_vecs == '0) ? VEC_W'(1) : num_vecs;
                        base  <= '0;
                        busy  <= 1'b1;
                        done  <= 1'b0;
                        state <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    acc     <= '0;
                    vec_idx <= '0;
                    state   <= ST_EVAL;
                end
                ST_EVAL: begin
                    det_mask  <= det;
                    det_valid <= 1'b1;
                    acc       <= acc | det;
                    if (vec_idx == nv_q - VEC_W'(1)) begin
                        lane_ptr <= LP_W'(1);
                        state    <= ST_REPORT;
                    end else begin
                        vec_idx <= vec_idx + VEC_W'(1);
                    end
                end
                ST_REPORT: begin
                    if (acc[lane_ptr]) begin
                        rpt_valid <= 1'b1;
                        rpt_fault <= rpt_id[FID_W-1:0];
                    end
                    if (lane_ptr == LP_W'(LANES - 1)) begin
                        if (last_batch) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            base  <= base + BASE_W'(LANES - 1);
                            state <= ST_CLEAR;
                        end
                    end else begin
                        lane_ptr <= lane_ptr + LP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the good lane is never flagged
    a_r2_lane0_clean: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> !det_mask[0]);

    // R5: lanes without a fault stay silent
    a_r5_unused_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> ((det_mask & ~lane_ok) == '0));

    // R4: sticky record only gains bits inside a batch
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && $past(state) == ST_EVAL) |-> (($past(acc) & ~acc) == '0));

    // R6: reported IDs lie inside the list
    a_r6_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (32'(rpt_fault) < NUM_FAULTS));

    // R7: finished and running are exclusive
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start pulse mid-sweep does not end the sweep
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_REPORT) |=> busy);
endmodule

// File: tb/fev_fault_eval_test.sv
module fev_fault_eval_test;
    localparam int LANES = 4;
    localparam int NF    = 13;
    localparam int VW    = 5;
    localparam int FW    = $clog2(NF);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VW-1:0]    num_vecs = '0;
    logic [VW-1:0]    vec_idx;
    logic [3:0]       vec_in = '0;
    logic             busy, done, det_valid, rpt_valid;
    logic [LANES-1:0] det_mask;
    logic [FW-1:0]    rpt_fault;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_mult = 1;
    int cur_off  = 0;

    fev_fault_eval #(.LANES(LANES), .NUM_FAULTS(NF), .VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_vecs(num_vecs),
        .vec_idx(vec_idx), .vec_in(vec_in), .busy(busy), .done(done),
        .det_valid(det_valid), .det_mask(det_mask),
        .rpt_valid(rpt_valid), .rpt_fault(rpt_fault)
    );

    always #10 clk = ~clk;

    // vector source: answers the requested index between edges
    always @(negedge clk) vec_in <= 4'((int'(vec_idx) * cur_mult + cur_off) & 15);

    function automatic logic [3:0] vec_of(input int idx);
        return 4'((idx * cur_mult + cur_off) & 15);
    endfunction

    // reference network with optional stuck-at fault (fid < 0: none), per R1
    function automatic logic [1:0] model(input logic [3:0] v, input int fid);
        logic l [8];
        for (int i = 0; i < 8; i++) begin
            case (i)
                0, 1, 2, 3: l[i] = v[i];
                4: l[i] = ~(l[0] & l[1]);
                5: l[i] = l[2] | l[3];
                6: l[i] = l[4] ^ l[2];
                default: l[i] = ~(l[5] & l[6]);
            endcase
            if (fid >= 0 && (fid >> 1) == i) l[i] = fid[0];
        end
        return {l[7], l[6]};
    endfunction

    function automatic logic detects(input int fid, input int idx);
        return model(vec_of(idx), fid) != model(vec_of(idx), -1);
    endfunction

    task automatic chk(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one full sweep; poke = 1 pulses start mid-sweep (R8)
    task automatic sweep(input int mult, input int off, input int nv, input bit poke);
        int eff = (nv == 0) ? 1 : nv;
        int nb  = (NF + LANES - 2) / (LANES - 1);
        int exp_ids [64];
        int n_exp = 0;
        int b = 0, v = 0, rp = 0, cyc = 0;
        cur_mult = mult;
        cur_off  = off;
        for (int bb = 0; bb < nb; bb++)
            for (int k = 1; k < LANES; k++) begin
                int fid = bb * (LANES - 1) + k - 1;
                bit hit = 0;
                if (fid < NF)
                    for (int i = 0; i < eff; i++) if (detects(fid, i)) hit = 1;
                if (hit) begin exp_ids[n_exp] = fid; n_exp++; end
            end
        @(negedge clk);
        num_vecs = VW'(nv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", busy, 1);
        chk("R7 done cleared by start", done, 0);
        do begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 3);
            if (poke && cyc == 3) num_vecs = 5'd2;
            if (det_valid) begin
                logic [LANES-1:0] em = '0;
                for (int k = 1; k < LANES; k++) begin
                    int fid = b * (LANES - 1) + k - 1;
                    if (fid < NF && detects(fid, v)) em[k] = 1'b1;
                end
                chk($sformatf("R1 R2 R3 mask batch %0d vec %0d", b, v), det_mask, em);
                chk("R2 lane0 clear", det_mask[0], 0);
                if (b == nb - 1)
                    chk("R5 unused lanes in last batch", det_mask >> (NF - b * (LANES - 1) + 1), 0);
                v++;
                if (v == eff) begin v = 0; b++; end
            end
            if (rpt_valid) begin
                chk($sformatf("R4 R6 report #%0d", rp), rpt_fault, (rp < n_exp) ? exp_ids[rp] : -1);
                rp++;
            end
        end while (!done && cyc < 5000);
        start = 1'b0;
        chk("R7 sweep finished", done, 1);
        chk("R6 batch count", b, nb);
        chk("R3 vectors per batch", v, 0);
        chk("R4 R6 report count", rp, n_exp);
        chk("R7 busy low at done", busy, 0);
        repeat (3) @(negedge clk);
        chk("R7 done holds", done, 1);
        chk("R7 idle no reports", rpt_valid | det_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset done", done, 0);
        chk("R9 reset det_valid", det_valid, 0);
        chk("R9 reset rpt_valid", rpt_valid, 0);
        sweep(1, 0, 16, 0);   // every input pattern
        sweep(3, 5, 4, 1);    // start pulse mid-sweep
        sweep(5, 2, 1, 0);    // single vector
        sweep(7, 9, 0, 0);    // zero taken as one
        sweep(11, 6, 7, 0);
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R7 sweep never finished actual=0 expected=1");
        summary();
        $finish;
    end
endmodule